// File: doc/BRIEF.md
# Four-Phase Clock and Fetch Pipeline Sequencer

The block turns a single input oscillator into four non-overlapping phase strobes. Each strobe lasts one oscillator period, and the four of them in rotation make one instruction cycle. A divided clock output runs at a quarter of the oscillator rate, so an outside observer can see the instruction rate.

Around these phases the block sequences a two-stage pipeline. Each instruction cycle fetches the next word while it executes the word fetched in the cycle before. The block emits the timing strobes that a datapath needs:

- advance the program counter in the first phase;
- load the instruction register in the first phase;
- read the data operand in the second phase;
- write the destination in the fourth phase;
- latch the fetched word in the fourth phase.

A single `branch_taken` input stands in for instruction decode. When it is high at the last phase of a valid execute cycle, the word already fetched is discarded. The next cycle then executes as a no-op (`flush`) while the branch target is fetched, so a taken branch costs exactly one extra cycle. The first cycle after reset only fetches.

Top module: `qseq_top`

## Requirements
- R1: While `rst` is high every strobe output is 0. The first phase strobe (`q_phase` bit 0) appears in the first clock after `rst` falls. After that, exactly one bit of `q_phase` is high in each clock, rotating bit 0, 1, 2, 3, 0, and so on.
- R2: `clkout` is high while `q_phase` bit 0 or bit 1 is high, and low while bit 2 or bit 3 is high. Its period is four clocks.
- R3: `pc_inc` is high in the first phase of every cycle. `fetch_latch` is high in the fourth phase of every cycle.
- R4: `ir_load` is high in the first phase of every cycle, including no-op cycles.
- R5: `dmem_rd` is high only in the second phase, and `dmem_wr` only in the fourth phase, and each only when `exec_valid` is 1.
- R6: In the first instruction cycle after reset, `exec_valid` is 0 and `flush` is 0, so no data read or write occurs.
- R7: If `branch_taken` is 1 at the fourth phase of a cycle with `exec_valid` 1, then the next cycle has `exec_valid` 0 and `flush` 1. The cycle after that is valid again unless something else intervenes.
- R8: `branch_taken` has no effect when `exec_valid` is 0, or when it is high only in phases other than the fourth. In those cases the next cycle has `exec_valid` 1 and `flush` 0.
- R9: `exec_valid` and `flush` change only at the boundary into the first phase. They are constant through all four phases of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator |
| rst | input | 1 | Synchronous active-high reset |
| branch_taken | input | 1 | Current instruction changes the program counter; sampled at the fourth phase |
| q_phase | output | 4 | One-hot phase strobes, bit 0 = first phase |
| clkout | output | 1 | Instruction-rate clock, high in phases one and two |
| pc_inc | output | 1 | Program counter increment strobe |
| fetch_latch | output | 1 | Fetched word latch strobe |
| ir_load | output | 1 | Instruction register load strobe |
| dmem_rd | output | 1 | Data operand read strobe |
| dmem_wr | output | 1 | Destination write strobe |
| exec_valid | output | 1 | Slot in execution is a real instruction |
| flush | output | 1 | Slot in execution was discarded by a taken branch |

## Verification
The assertions check on every clock:
- the phase strobes stay one-hot and rotate;
- `clkout` rises only at the first phase;
- the slot flags stay constant within a cycle;
- a write strobe never appears in an invalid slot;
- a branch in a valid slot always leads to a flushed slot.

Some behaviours only the bench scenarios can show:
- the exact cycle count of a taken branch;
- branches arriving back to back, or inside an already flushed slot;
- branch pulses that miss the fourth phase;
- the fetch-only first cycle after a reset applied in the middle of a run.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    localparam int unsigned NUM_PHASES  = 4;
    localparam int unsigned PH_W        = $clog2(NUM_PHASES);
    localparam int unsigned CLKOUT_HIGH = NUM_PHASES / 2;

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t PH_FIRST = phase_t'(0);
    localparam phase_t PH_READ  = phase_t'(1);
    localparam phase_t PH_LAST  = phase_t'(NUM_PHASES - 1);

    typedef struct packed {
        logic pc_inc;
        logic fetch_latch;
        logic ir_load;
        logic dmem_rd;
        logic dmem_wr;
    } strobe_t;

    function automatic phase_t phase_next(input phase_t p);
        return (p == PH_LAST) ? PH_FIRST : phase_t'(p + 1'b1);
    endfunction
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
    import qseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output phase_t                phase,
    output logic                  run,
    output logic [NUM_PHASES-1:0] q_onehot,
    output logic                  clkout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LAST;
            run   <= 1'b0;
        end else begin
            phase <= phase_next(phase);
            run   <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
        assign q_onehot[i] = run && (phase == phase_t'(i));
    end

    assign clkout = run && (int'(phase) < CLKOUT_HIGH);

    p_one_phase_r1: assert property (@(posedge clk) disable iff (rst)
        run |-> ($countones(q_onehot) == 1));

    p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
        run |=> (q_onehot == {$past(q_onehot[NUM_PHASES-2:0]), $past(q_onehot[NUM_PHASES-1])}));

    p_clk_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(clkout) |-> q_onehot[0]);
endmodule

// File: rtl/qseq_slot_ctrl.sv
module qseq_slot_ctrl
    import qseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  phase_t phase,
    input  logic   branch_taken,
    output logic   exec_valid,
    output logic   flush
);
    logic boundary;
    logic taken;

    assign boundary = run && (phase == PH_LAST);
    assign taken    = exec_valid && branch_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_valid <= 1'b0;
            flush      <= 1'b0;
        end else if (boundary) begin
            exec_valid <= !taken;
            flush      <= taken;
        end
    end

    p_branch_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (boundary && exec_valid && branch_taken) |=> (flush && !exec_valid));

    p_ignore_invalid_r8: assert property (@(posedge clk) disable iff (rst)
        (boundary && !exec_valid) |=> (exec_valid && !flush));

    p_hold_in_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (run && phase != PH_FIRST) |-> ($stable(exec_valid) && $stable(flush)));
endmodule

// File: rtl/qseq_strobes.sv
module qseq_strobes
    import qseq_pkg::*;
(
    input  logic    run,
    input  phase_t  phase,
    input  logic    exec_valid,
    output strobe_t strb
);
    always_comb begin
        strb             = '0;
        strb.pc_inc      = run && (phase == PH_FIRST);
        strb.ir_load     = run && (phase == PH_FIRST);
        strb.fetch_latch = run && (phase == PH_LAST);
        strb.dmem_rd     = run && exec_valid && (phase == PH_READ);
        strb.dmem_wr     = run && exec_valid && (phase == PH_LAST);
    end
endmodule

// File: rtl/qseq_top.sv
module qseq_top
    import qseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  branch_taken,
    output logic [NUM_PHASES-1:0] q_phase,
    output logic                  clkout,
    output logic                  pc_inc,
    output logic                  fetch_latch,
    output logic                  ir_load,
    output logic                  dmem_rd,
    output logic                  dmem_wr,
    output logic                  exec_valid,
    output logic                  flush
);
    phase_t  phase;
    logic    run;
    strobe_t strb;

    qseq_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .run      (run),
        .q_onehot (q_phase),
        .clkout   (clkout)
    );

    qseq_slot_ctrl u_slot (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .phase        (phase),
        .branch_taken (branch_taken),
        .exec_valid   (exec_valid),
        .flush        (flush)
    );

    qseq_strobes u_strb (
        .run        (run),
        .phase      (phase),
        .exec_valid (exec_valid),
        .strb       (strb)
    );

    assign pc_inc      = strb.pc_inc;
    assign fetch_latch = strb.fetch_latch;
    assign ir_load     = strb.ir_load;
    assign dmem_rd     = strb.dmem_rd;
    assign dmem_wr     = strb.dmem_wr;

    p_wr_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        dmem_wr |-> (exec_valid && q_phase[NUM_PHASES-1]));

    p_rd_phase_r5: assert property (@(posedge clk) disable iff (rst)
        dmem_rd |-> (exec_valid && q_phase[1]));
endmodule

// File: tb/tb_qseq_top.sv
module tb_qseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       branch_taken = 1'b0;
    logic [3:0] q_phase;
    logic       clkout, pc_inc, fetch_latch, ir_load, dmem_rd, dmem_wr, exec_valid, flush;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    qseq_top dut (
        .clk(clk), .rst(rst), .branch_taken(branch_taken),
        .q_phase(q_phase), .clkout(clkout), .pc_inc(pc_inc),
        .fetch_latch(fetch_latch), .ir_load(ir_load),
        .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .exec_valid(exec_valid), .flush(flush)
    );

    // one entry per instruction cycle: {branch_taken, expected exec_valid, expected flush}
    localparam int NVEC = 11;
    localparam logic [2:0] VEC [0:NVEC-1] = '{
        3'b100,  // R6 fetch-only first cycle; branch ignored (R8)
        3'b010,
        3'b110,  // taken branch in valid slot
        3'b101,  // R7 flushed; branch here ignored (R8)
        3'b010,
        3'b010,
        3'b110,
        3'b001,  // R7 flushed slot
        3'b110,
        3'b101,
        3'b010
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_phase(input int p, input logic v, input logic f);
        check("R1", "q_phase", int'(q_phase), 1 << p);
        check("R2", "clkout", int'(clkout), int'(p < 2));
        check("R3", "pc_inc", int'(pc_inc), int'(p == 0));
        check("R3", "fetch_latch", int'(fetch_latch), int'(p == 3));
        check("R4", "ir_load", int'(ir_load), int'(p == 0));
        check("R5", "dmem_rd", int'(dmem_rd), int'(p == 1 && v));
        check("R5", "dmem_wr", int'(dmem_wr), int'(p == 3 && v));
        check("R9", "exec_valid", int'(exec_valid), int'(v));
        check("R9", "flush", int'(flush), int'(f));
    endtask

    task automatic check_idle();
        check("R1", "reset q_phase", int'(q_phase), 0);
        check("R1", "reset strobes",
              int'({clkout, pc_inc, fetch_latch, ir_load, dmem_rd, dmem_wr, exec_valid, flush}), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle();
        rst = 1'b0;
        @(negedge clk);  // first Q1 after release (R1)

        for (int c = 0; c < NVEC; c++) begin
            branch_taken = VEC[c][2];
            for (int p = 0; p < 4; p++) begin
                check_phase(p, VEC[c][1], VEC[c][0]);
                @(negedge clk);
            end
        end

        // R8: branch pulse in phases 1..3 only, dropped before phase 4
        branch_taken = 1'b1;
        repeat (3) @(negedge clk);
        branch_taken = 1'b0;
        check("R8", "pulse q_phase", int'(q_phase), 8);
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            check_phase(p, 1'b1, 1'b0);
            @(negedge clk);
        end

        // R1/R6: reset in the middle of a cycle
        @(negedge clk);  // now in phase 2
        rst = 1'b1;
        @(negedge clk);
        check_idle();
        @(negedge clk);
        check_idle();
        rst = 1'b0;
        @(negedge clk);
        branch_taken = 1'b1;  // ignored in fetch-only cycle (R8)
        for (int p = 0; p < 4; p++) begin
            check_phase(p, 1'b0, 1'b0);  // R6
            @(negedge clk);
        end
        branch_taken = 1'b1;  // R7 taken in valid slot
        for (int p = 0; p < 4; p++) begin
            check_phase(p, 1'b1, 1'b0);
            @(negedge clk);
        end
        branch_taken = 1'b0;
        for (int p = 0; p < 4; p++) begin
            check_phase(p, 1'b0, 1'b1);  // R7 one no-op cycle
            @(negedge clk);
        end
        for (int p = 0; p < 4; p++) begin
            check_phase(p, 1'b1, 1'b0);  // R7 target executes
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule